// File: doc/BRIEF.md
# TDM Multichannel PCM Serial Port

This block moves byte-wide voice samples for a small bank of telephony channels over a time-division-multiplexed serial link. It runs directly on the incoming bit clock. It divides that clock into frames of `FRAME_CLKS` bit periods, and each frame is split into slots of `SLOT_W` bits. It drives a one-clock frame sync at the start of every frame. Only the first `ACTIVE_SLOTS` slots carry traffic. The transmit line is driven only in those slots. In all later slots the line is released to high impedance, and any bits received there are discarded.

On the transmit side, the block asks for the next byte one bit period before that slot begins, using a ready/valid handshake and a channel index. It then shifts the byte out MSB first. The first bit of slot 0 goes out in the same clock as the frame sync. On the receive side, the block assembles each active slot MSB first. It presents the byte with its channel index as a one-cycle valid pulse, and that pulse cannot be stalled.

Two sticky flags record service errors. If no byte was offered when one was requested, the block sends an all-ones filler byte and sets the underrun flag. If a received byte was not accepted, it sets the overrun flag. The port stays idle until enable is raised, so the buffering logic around it can prepare both directions first.

Top module: `tdm_pcm_port`

## Requirements
- R1: While reset is asserted, and afterwards while enable is low, the block drives no frame sync, no start-of-frame strobe, no output enable, no transmit ready and no receive valid. Both sticky flags read 0.
- R2: After enable rises, the first frame sync appears in the clock that follows the first cycle in which enable is high. After that, frame sync is one clock wide and repeats every FRAME_CLKS clocks. The start-of-frame strobe pulses in the same clocks.
- R3: In an active slot, the sdo_o line carries the slot's byte MSB first, one bit per clock. Bit 7 of slot 0 is driven in the same clock as the frame sync.
- R4: The tx_ready_o signal is high only in the last bit clock before an active slot, and only while enable is high. For slot 0 this clock is the last clock of the previous frame or the first enabled cycle. During ready, tx_slot_o gives the channel number of the upcoming slot, and the byte on tx_data_i is taken if tx_valid_i is high.
- R5: If tx_valid_i is low while tx_ready_o is high, the slot sends 0xFF and underrun_o becomes 1. It stays 1 until reset.
- R6: In slots numbered ACTIVE_SLOTS and above, sdo_oe_o is low and sdo_o is high impedance. Data on sdi_i in those slots produces no receive valid.
- R7: The sdi_i line is sampled on the rising edge that ends each bit clock of an active slot, MSB first. In the clock after the last bit of that slot, rx_valid_o pulses for one cycle, with the byte on rx_data_o and the channel number on rx_slot_o.
- R8: If rx_valid_o is high while rx_ready_i is low, overrun_o becomes 1. It stays 1 until reset.
- R9: When enable is low at a rising edge, the next clock has no output enable and no frame sync. The next enable restarts the frame from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| tx_data_i | input | SLOT_W | Transmit byte for the requested slot |
| tx_valid_i | input | 1 | Transmit byte is present |
| tx_ready_o | output | 1 | Request for the next slot's byte |
| tx_slot_o | output | CH_W | Channel of the requested byte |
| rx_data_o | output | SLOT_W | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_ready_i | input | 1 | Sink accepts the received byte |
| rx_slot_o | output | CH_W | Channel of the received byte |
| sdi_i | input | 1 | Serial receive data |
| sdo_o | output | 1 | Serial transmit data, high impedance outside active slots |
| sdo_oe_o | output | 1 | Transmit line driven |
| fsync_o | output | 1 | Frame sync pin |
| sof_o | output | 1 | Start-of-frame strobe |
| underrun_o | output | 1 | Sticky transmit underrun |
| overrun_o | output | 1 | Sticky receive overrun |

## Verification
The transmit path is driven with a byte pattern that changes on every fetch, so a swapped bit order or a slot shifted by one clock shows up at once. A frame in which only channel 3 is withheld separates the filler-byte path from normal shifting. The receive line carries a distinct byte per active slot and toggling noise in idle slots, which tells correct window gating apart from capture in every slot. A short drop of rx_ready_i, and a mid-frame disable followed by a restart, exercise the flags and show whether the frame restarts cleanly at slot 0.

// File: rtl/tdm_pcm_pkg.sv
package tdm_pcm_pkg;
  parameter int unsigned DEF_SLOT_W   = 8;
  parameter int unsigned DEF_ACTIVE   = 8;
  parameter int unsigned DEF_FRAME    = 256;

  // index width that never collapses to zero
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_pcm_pkg::*;
#(
  parameter int unsigned SLOT_W  = DEF_SLOT_W,
  parameter int unsigned NSLOT   = DEF_FRAME / DEF_SLOT_W,
  parameter int unsigned ACTIVE  = DEF_ACTIVE,
  localparam int unsigned BIT_W  = idx_w(SLOT_W),
  localparam int unsigned SIDX_W = idx_w(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic              run_o,
  output logic              last_bit_o,
  output logic [SIDX_W-1:0] slot_o,
  output logic [SIDX_W-1:0] nxt_slot_o,
  output logic              slot_act_o,
  output logic              nxt_act_o,
  output logic              frame_start_o
);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_W - 1);
  localparam logic [SIDX_W-1:0] SLOT_LAST = SIDX_W'(NSLOT - 1);

  logic [BIT_W-1:0]  bit_q;
  logic [SIDX_W-1:0] slot_q;
  logic              run_q;

  // parked on the last bit of the last slot while idle: the enable cycle is the slot-0 fetch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= BIT_LAST;
      slot_q <= SLOT_LAST;
      run_q  <= 1'b0;
    end else if (!en_i) begin
      bit_q  <= BIT_LAST;
      slot_q <= SLOT_LAST;
      run_q  <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (bit_q == BIT_LAST) begin
        bit_q  <= '0;
        slot_q <= nxt_slot_o;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign nxt_slot_o    = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
  assign last_bit_o    = (bit_q == BIT_LAST);
  assign run_o         = run_q;
  assign slot_o        = slot_q;
  assign slot_act_o    = run_q && (32'(slot_q) < ACTIVE);
  assign nxt_act_o     = 32'(nxt_slot_o) < ACTIVE;
  assign frame_start_o = run_q && (slot_q == '0) && (bit_q == '0);
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
  import tdm_pcm_pkg::*;
#(
  parameter int unsigned SLOT_W = DEF_SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] data_i,
  input  logic              valid_i,
  output logic              sd_o,
  output logic              underrun_o
);
  logic [SLOT_W-1:0] sh_q;
  logic              und_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      und_q <= 1'b0;
    end else if (load_i) begin
      sh_q <= valid_i ? data_i : '1;
      if (!valid_i) und_q <= 1'b1;
    end else begin
      sh_q <= {sh_q[SLOT_W-2:0], 1'b1};
    end
  end

  assign sd_o       = sh_q[SLOT_W-1];
  assign underrun_o = und_q;
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
  import tdm_pcm_pkg::*;
#(
  parameter int unsigned SLOT_W = DEF_SLOT_W,
  parameter int unsigned CH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              last_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              sd_i,
  input  logic              ready_i,
  output logic [SLOT_W-1:0] data_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              valid_o,
  output logic              overrun_o
);
  logic [SLOT_W-1:0] acc_q;
  logic              ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      data_o  <= '0;
      ch_o    <= '0;
      valid_o <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (valid_o && !ready_i) ovr_q <= 1'b1;
      if (cap_i) acc_q <= {acc_q[SLOT_W-2:0], sd_i};
      if (cap_i && last_i) begin
        data_o  <= {acc_q[SLOT_W-2:0], sd_i};
        ch_o    <= ch_i;
        valid_o <= 1'b1;
      end else begin
        valid_o <= 1'b0;
      end
    end
  end

  assign overrun_o = ovr_q;
endmodule

// File: rtl/tdm_pcm_port.sv
module tdm_pcm_port
  import tdm_pcm_pkg::*;
#(
  parameter int unsigned SLOT_W       = DEF_SLOT_W,
  parameter int unsigned ACTIVE_SLOTS = DEF_ACTIVE,
  parameter int unsigned FRAME_CLKS   = DEF_FRAME,
  localparam int unsigned NSLOT       = FRAME_CLKS / SLOT_W,
  localparam int unsigned SIDX_W      = idx_w(NSLOT),
  localparam int unsigned CH_W        = idx_w(ACTIVE_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SLOT_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [CH_W-1:0]   tx_slot_o,
  output logic [SLOT_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [CH_W-1:0]   rx_slot_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              fsync_o,
  output logic              sof_o,
  output logic              underrun_o,
  output logic              overrun_o
);
  logic              run, last_bit, slot_act, nxt_act, frame_start, tx_bit;
  logic [SIDX_W-1:0] slot, nxt_slot;

  tdm_frame_timer #(
    .SLOT_W (SLOT_W),
    .NSLOT  (NSLOT),
    .ACTIVE (ACTIVE_SLOTS)
  ) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .run_o         (run),
    .last_bit_o    (last_bit),
    .slot_o        (slot),
    .nxt_slot_o    (nxt_slot),
    .slot_act_o    (slot_act),
    .nxt_act_o     (nxt_act),
    .frame_start_o (frame_start)
  );

  // fetch one bit early so the MSB is ready on the first clock of the slot
  assign tx_ready_o = en_i && last_bit && nxt_act;
  assign tx_slot_o  = CH_W'(nxt_slot);

  tdm_tx_lane #(
    .SLOT_W (SLOT_W)
  ) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tx_ready_o),
    .data_i     (tx_data_i),
    .valid_i    (tx_valid_i),
    .sd_o       (tx_bit),
    .underrun_o (underrun_o)
  );

  tdm_rx_lane #(
    .SLOT_W (SLOT_W),
    .CH_W   (CH_W)
  ) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (slot_act),
    .last_i    (last_bit),
    .ch_i      (CH_W'(slot)),
    .sd_i      (sdi_i),
    .ready_i   (rx_ready_i),
    .data_o    (rx_data_o),
    .ch_o      (rx_slot_o),
    .valid_o   (rx_valid_o),
    .overrun_o (overrun_o)
  );

  assign sdo_oe_o = slot_act;
  assign sdo_o    = slot_act ? tx_bit : 1'bz;
  assign fsync_o  = frame_start;
  assign sof_o    = frame_start;

  logic unused_run;
  assign unused_run = run;
endmodule

// File: rtl/tdm_pcm_port_chk.sv
module tdm_pcm_port_chk #(
  parameter int unsigned FRAME_CLKS = 256
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic sdo_oe_o,
  input logic fsync_o,
  input logic underrun_o,
  input logic overrun_o
);
  int unsigned gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (!en_i) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (fsync_o) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  a_r2_fsync_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |=> !fsync_o);
  a_r2_fsync_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsync_o && seen_q) |-> (gap_q == FRAME_CLKS - 1));
  a_r3_fsync_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> sdo_oe_o);
  a_r4_ready_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> en_i);
  a_r5_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);
  a_r5_underrun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(tx_ready_o && !tx_valid_i));
  a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  a_r7_valid_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(sdo_oe_o));
  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  a_r9_disable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sdo_oe_o && !fsync_o));
endmodule

bind tdm_pcm_port tdm_pcm_port_chk #(.FRAME_CLKS(FRAME_CLKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o),
  .sdo_oe_o   (sdo_oe_o),
  .fsync_o    (fsync_o),
  .underrun_o (underrun_o),
  .overrun_o  (overrun_o)
);

// File: tb/tdm_pcm_port_tb_top.sv
module tdm_pcm_port_tb_top;
  localparam int FR = 256;
  localparam int SW = 8;
  localparam int NA = 8;

  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b1, rx_ready = 1'b1, sdi = 1'b0;
  logic       tx_ready, rx_valid, sdo_oe, fsync, sof, und, ovr;
  logic [2:0] tx_slot, rx_slot;
  logic [7:0] rx_data;
  wire        sdo;

  always #10 clk = ~clk;

  tdm_pcm_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_slot_o(tx_slot),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_slot_o(rx_slot),
    .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .fsync_o(fsync), .sof_o(sof),
    .underrun_o(und), .overrun_o(ovr)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  int   m_pos = FR - 1, m_fetch = 0, m_rxn = 0;
  bit   m_run = 0, m_rxv = 0, m_und = 0, m_ovr = 0, m_fetch_now;
  logic [7:0] m_txb = 8'hFF;
  bit   drop3 = 0, drop_all = 0;
  logic [7:0] rxq_data[$];
  int         rxq_slot[$];

  function automatic logic [7:0] tx_pat(int n);
    return 8'(8'hA5 ^ (n * 29));
  endfunction
  function automatic logic [7:0] rx_pat(int n);
    return 8'(8'h3C + n * 71);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = FR - 1; m_run = 0; m_rxv = 0; m_und = 0; m_ovr = 0; m_txb = 8'hFF;
    end else begin
      m_fetch_now = en && (m_pos % SW == SW - 1) && ((((m_pos + 1) % FR) / SW) < NA);
      if (m_rxv && !rx_ready) m_ovr = 1;
      m_rxv = m_run && (m_pos / SW < NA) && (m_pos % SW == SW - 1);
      if (m_fetch_now) begin
        if (!tx_valid) m_und = 1;
        m_txb = tx_valid ? tx_data : 8'hFF;
        m_fetch++;
      end
      if (!en) begin m_run = 0; m_pos = FR - 1; end
      else begin m_run = 1; m_pos = (m_pos + 1) % FR; end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (pos %0d)", tag, what, act, exp, m_pos);
    end
  endtask

  // per-clock comparison, called at the falling edge before inputs change
  task automatic compare_all();
    int  sl = m_pos / SW, bt = m_pos % SW, ns = ((m_pos + 1) % FR) / SW;
    bit  e_fs = m_run && m_pos == 0;
    bit  e_oe = m_run && sl < NA;
    bit  e_rd = en && bt == SW - 1 && ns < NA;
    string tq = !rst_n ? "R1" : (!m_run ? "R9" : "R2");
    chk(tq, "fsync", fsync, e_fs);
    chk(tq, "sof", sof, e_fs);
    chk(!rst_n ? "R1" : "R6", "sdo_oe", sdo_oe, e_oe);
    if (e_oe) chk("R3", "sdo bit", sdo, m_txb[SW - 1 - bt]);
    chk(!rst_n ? "R1" : "R4", "tx_ready", tx_ready, e_rd);
    if (e_rd) chk("R4", "tx_slot", tx_slot, 32'(ns % NA));
    chk(!rst_n ? "R1" : "R7", "rx_valid", rx_valid, m_rxv);
    chk(!rst_n ? "R1" : "R5", "underrun", und, m_und);
    chk(!rst_n ? "R1" : "R8", "overrun", ovr, m_ovr);
    if (rx_valid) begin
      if (rxq_data.size() == 0) chk("R6", "rx without slot", 1, 0);
      else begin
        chk("R7", "rx_data", rx_data, rxq_data.pop_front());
        chk("R7", "rx_slot", rx_slot, rxq_slot.pop_front());
      end
    end
  endtask

  task automatic drive_inputs();
    int sl = m_pos / SW, bt = m_pos % SW, ns = ((m_pos + 1) % FR) / SW;
    tx_data  = tx_pat(m_fetch);
    tx_valid = !(drop_all || (drop3 && ns == 3));
    if (m_run && sl < NA) begin
      sdi = rx_pat(m_rxn)[SW - 1 - bt];
      if (bt == SW - 1) begin
        rxq_data.push_back(rx_pat(m_rxn));
        rxq_slot.push_back(sl);
        m_rxn++;
      end
    end else begin
      sdi = m_pos[0] ^ m_pos[3]; // noise, must be ignored
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      drive_inputs();
    end
  endtask

  initial begin
    step(3);
    chk("R1", "flags in reset", {30'd0, und, ovr}, 0);
    rst_n = 1'b1;
    step(5);
    chk("R1", "idle oe", sdo_oe, 0);
    en = 1'b1;                      // next falling edge sees the enable cycle
    step(1);
    chk("R2", "first fsync", fsync, 1);
    step(2 * FR);
    chk("R5", "no underrun yet", und, 0);
    chk("R8", "no overrun yet", ovr, 0);
    drop3 = 1; step(FR); drop3 = 0;
    chk("R5", "underrun set", und, 1);
    step(FR);
    chk("R5", "underrun sticky", und, 1);
    while (m_pos != 30) step(1);
    rx_ready = 1'b0; step(12); rx_ready = 1'b1;
    chk("R8", "overrun set", ovr, 1);
    while (m_pos != 100) step(1);
    en = 1'b0;
    step(2);
    chk("R9", "quiet after disable", {30'd0, sdo_oe, fsync}, 0);
    step(20);
    en = 1'b1;
    step(1);
    chk("R9", "restart at slot 0", fsync, 1);
    drop_all = 1; step(FR); drop_all = 0;
    step(FR + 8);
    chk("R7", "rx queue drained", rxq_data.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule